// File: doc/BRIEF.md
# Main Control Decoder for a Single-Cycle Datapath

This block turns the 6-bit major opcode of a fetched instruction into the control lines for a single-cycle datapath. Those lines are:

- the destination register select;
- the ALU second-operand select;
- the write-back source select;
- the register-file and data-memory write enables;
- the next-PC branch select;
- the immediate extension mode;
- a 3-bit ALU class code.

A separate local ALU decoder refines the ALU class code with the function field.

The decoder is purely combinational. Its structure has two planes, as in a PLA:

- An AND plane fully matches the opcode against the five known instruction kinds: register-register, OR-immediate, load word, store word and branch-if-equal.
- An OR plane then sums the selected match terms for each output.

Outputs that would be don't-cares in a hand-made table are driven to 0. An opcode outside the five known kinds gives all outputs 0. In that case no register or memory write happens and no branch is taken.

Top module: `main_ctrl_dec`

## Requirements
- R1: The register-file write enable `rf_we` is 1 exactly for opcodes 000000 (register-register), 001101 (OR-immediate) and 100011 (load word). It is 0 for every other opcode.
- R2: The data-memory write enable `dm_we` is 1 exactly for opcode 101011 (store word).
- R3: The branch select `pc_branch` is 1 exactly for opcode 000100 (branch-if-equal). When it is 0, the next PC is the sequential one.
- R4: `wr_dst_rd` (1 = destination from the third register field, 0 = from the second) is 1 only for opcode 000000. It is 0 for all other opcodes.
- R5: `srcb_imm` (1 = immediate operand, 0 = second register) is 1 for opcodes 001101, 100011 and 101011, and 0 otherwise.
- R6: `wb_mem` (1 = write back memory data, 0 = ALU result) is 1 only for opcode 100011.
- R7: `imm_sext` (1 = sign extension, 0 = zero extension) is 1 for opcodes 100011 and 101011. It is 0 for 001101 and for every other opcode.
- R8: `alu_class` is 3'b100 for 000000, 3'b010 for 001101 (OR), 3'b000 for 100011 and 101011 (add), 3'b001 for 000100 (subtract), and 3'b000 for any other opcode.
- R9: Any opcode other than the five listed drives all ten output bits to 0.
- R10: At most one of `rf_we`, `dm_we` and `pc_branch` is 1 for any opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Major opcode field of the instruction |
| wr_dst_rd | output | 1 | Destination register field select |
| srcb_imm | output | 1 | ALU second operand from the immediate |
| wb_mem | output | 1 | Write-back data taken from data memory |
| rf_we | output | 1 | Register-file write enable |
| dm_we | output | 1 | Data-memory write enable |
| pc_branch | output | 1 | Next-PC branch select |
| imm_sext | output | 1 | Immediate is sign-extended |
| alu_class | output | 3 | ALU class code for the local ALU decoder |

## Verification
The decoder holds no state, so a wrong term shows up on the output ports in the same cycle as the opcode that exercises it. Three kinds of error are caught this way:

- A match constant with a flipped bit makes one known opcode decode as undefined, giving all zeros. It can also make an undefined opcode alias onto a known kind.
- A wrong OR-plane mask moves a single control line.
- A missed don't-care leaves a stray 1 that would fire a write or a branch.

The bench sweeps all 64 opcodes, so every aliasing or mask error appears within one sweep.

// File: rtl/main_ctrl_dec_pkg.sv
package main_ctrl_dec_pkg;
  localparam int OP_W    = 6;
  localparam int NKIND   = 5;
  localparam int ALUC_W  = 3;
  localparam int NCOL    = 7 + ALUC_W;

  // kind indices in the match vector
  localparam int K_RR  = 0;
  localparam int K_ORI = 1;
  localparam int K_LDW = 2;
  localparam int K_STW = 3;
  localparam int K_BEQ = 4;

  // column indices in the control word
  localparam int C_DST  = 0;
  localparam int C_BIMM = 1;
  localparam int C_WBM  = 2;
  localparam int C_RFWE = 3;
  localparam int C_DMWE = 4;
  localparam int C_BR   = 5;
  localparam int C_SEXT = 6;
  localparam int C_ALU  = 7;

  function automatic logic [OP_W-1:0] kind_code(input int k);
    case (k)
      K_RR:    kind_code = 6'b000000;
      K_ORI:   kind_code = 6'b001101;
      K_LDW:   kind_code = 6'b100011;
      K_STW:   kind_code = 6'b101011;
      default: kind_code = 6'b000100;
    endcase
  endfunction

  // which kinds feed each column (bit k = kind k)
  function automatic logic [NKIND-1:0] col_mask(input int c);
    case (c)
      C_DST:     col_mask = 5'b00001;
      C_BIMM:    col_mask = 5'b01110;
      C_WBM:     col_mask = 5'b00100;
      C_RFWE:    col_mask = 5'b00111;
      C_DMWE:    col_mask = 5'b01000;
      C_BR:      col_mask = 5'b10000;
      C_SEXT:    col_mask = 5'b01100;
      C_ALU:     col_mask = 5'b10000;
      C_ALU + 1: col_mask = 5'b00010;
      C_ALU + 2: col_mask = 5'b00001;
      default:   col_mask = 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/main_ctrl_match.sv
module main_ctrl_match
  import main_ctrl_dec_pkg::*;
#(
  parameter int W  = OP_W,
  parameter int NK = NKIND
) (
  input  logic [W-1:0]  op,
  output logic [NK-1:0] hit
);
  for (genvar k = 0; k < NK; k++) begin : g_term
    localparam logic [W-1:0] CODE = kind_code(k);
    assign hit[k] = (op == CODE);
  end

  always_comb begin
    if (!$isunknown(op)) begin
      assert_single_kind_R9 : assert ($onehot0(hit))
        else $error("more than one kind matched");
    end
  end
endmodule

// File: rtl/main_ctrl_plane.sv
module main_ctrl_plane
  import main_ctrl_dec_pkg::*;
#(
  parameter int NK = NKIND,
  parameter int NC = NCOL
) (
  input  logic [NK-1:0] hit,
  output logic [NC-1:0] ctl
);
  for (genvar c = 0; c < NC; c++) begin : g_col
    localparam logic [NK-1:0] MASK = col_mask(c);
    assign ctl[c] = |(hit & MASK);
  end
endmodule

// File: rtl/main_ctrl_dec.sv
module main_ctrl_dec
  import main_ctrl_dec_pkg::*;
(
  input  logic [5:0] op_code,
  output logic       wr_dst_rd,
  output logic       srcb_imm,
  output logic       wb_mem,
  output logic       rf_we,
  output logic       dm_we,
  output logic       pc_branch,
  output logic       imm_sext,
  output logic [2:0] alu_class
);
  logic [NKIND-1:0] hit;
  logic [NCOL-1:0]  ctl;

  main_ctrl_match #(.W(OP_W), .NK(NKIND)) u_match (.op(op_code), .hit(hit));
  main_ctrl_plane #(.NK(NKIND), .NC(NCOL)) u_plane (.hit(hit), .ctl(ctl));

  assign wr_dst_rd = ctl[C_DST];
  assign srcb_imm  = ctl[C_BIMM];
  assign wb_mem    = ctl[C_WBM];
  assign rf_we     = ctl[C_RFWE];
  assign dm_we     = ctl[C_DMWE];
  assign pc_branch = ctl[C_BR];
  assign imm_sext  = ctl[C_SEXT];
  assign alu_class = ctl[C_ALU +: ALUC_W];

  always_comb begin
    if (!$isunknown(op_code)) begin
      assert_one_effect_R10 : assert ($countones({rf_we, dm_we, pc_branch}) <= 1)
        else $error("write and branch overlap");
      assert_store_only_R2 : assert (!dm_we || op_code == 6'b101011)
        else $error("memory write on wrong opcode");
      assert_branch_only_R3 : assert (!pc_branch || op_code == 6'b000100)
        else $error("branch on wrong opcode");
      assert_rf_we_kinds_R1 : assert (!rf_we || op_code == 6'b000000 ||
                                      op_code == 6'b001101 || op_code == 6'b100011)
        else $error("register write on wrong opcode");
      assert_load_wb_R6 : assert (!wb_mem || (rf_we && srcb_imm && imm_sext))
        else $error("memory write-back without load controls");
      assert_idle_unknown_R9 : assert (hit != '0 ||
                                       {wr_dst_rd, srcb_imm, wb_mem, rf_we, dm_we,
                                        pc_branch, imm_sext, alu_class} == '0)
        else $error("undefined opcode drove a control");
    end
  end
endmodule

// File: tb/main_ctrl_dec_bench.sv
`timescale 1ns/1ps
module main_ctrl_dec_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [5:0] op_code = '0;
  logic wr_dst_rd, srcb_imm, wb_mem, rf_we, dm_we, pc_branch, imm_sext;
  logic [2:0] alu_class;

  main_ctrl_dec u_main_ctrl_dec (
    .op_code(op_code), .wr_dst_rd(wr_dst_rd), .srcb_imm(srcb_imm),
    .wb_mem(wb_mem), .rf_we(rf_we), .dm_we(dm_we), .pc_branch(pc_branch),
    .imm_sext(imm_sext), .alu_class(alu_class));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp, input logic [5:0] op);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%b actual=%0d expected=%0d", req, op, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) begin
      logic [5:0] o;
      bit rr, ori, ldw, stw, beq, known;
      int exp_alu;
      o = 6'(i);
      rr = (i == 0); ori = (i == 13); ldw = (i == 35); stw = (i == 43); beq = (i == 4);
      known = rr | ori | ldw | stw | beq;
      exp_alu = rr ? 4 : ori ? 2 : beq ? 1 : 0;
      @(negedge clk);
      op_code = o;
      #0.5;
      chk("R1 rf_we", int'(rf_we), int'(rr | ori | ldw), o);
      chk("R2 dm_we", int'(dm_we), int'(stw), o);
      chk("R3 pc_branch", int'(pc_branch), int'(beq), o);
      chk("R4 wr_dst_rd", int'(wr_dst_rd), int'(rr), o);
      chk("R5 srcb_imm", int'(srcb_imm), int'(ori | ldw | stw), o);
      chk("R6 wb_mem", int'(wb_mem), int'(ldw), o);
      chk("R7 imm_sext", int'(imm_sext), int'(ldw | stw), o);
      chk("R8 alu_class", int'(alu_class), exp_alu, o);
      if (!known)
        chk("R9 all-zero", int'({wr_dst_rd, srcb_imm, wb_mem, rf_we, dm_we,
                                 pc_branch, imm_sext, alu_class}), 0, o);
      chk("R10 single effect", int'(int'(rf_we) + int'(dm_we) + int'(pc_branch) <= 1), 1, o);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule